// File: doc/BRIEF.md
# IO Bank Freeze/Thaw Sequencer

This block steps the pad-control lines of several general-purpose IO banks between a frozen state and a thawed (released) state. It never moves all the lines at once. Each bank has five control outputs: slew enable, weak pull-up and tristate (all active low), bus-hold (active low) and configuration-done (active high). A one-cycle freeze or thaw request starts an ordered sequence of steps. Each step holds its group of lines for a minimum number of clocks before the next group moves. The thaw order is the reverse of the freeze order.

Each bank has its own state machine, spacing timer, frozen/thawed flag and busy flag. A parameter sets how many banks are built. After reset every bank is frozen, with all five lines low. The minimum spacing is set as a time in picoseconds together with the clock period. The block rounds it up to whole cycles, with a floor of one cycle.

State machine per bank, with its states and transitions:
- `ST_FROZEN`: idle and frozen. A thaw request without a freeze request moves it to `ST_THW_CFG`.
- `ST_THW_CFG`: bus-hold is released and configuration-done is raised. When the gap expires it moves to `ST_THW_PAD`.
- `ST_THW_PAD`: pull-up and tristate are also released. When the gap expires it moves to `ST_THAWED`.
- `ST_THAWED`: idle with all lines high. A freeze request moves it to `ST_FRZ_PAD`.
- `ST_FRZ_PAD`: slew, pull-up and tristate are asserted low. When the gap expires it moves to `ST_FROZEN`, which also drops bus-hold and configuration-done.

Top module: `iofrz_seq_top`

## Requirements
- R1: After reset every bank shows slew_n, pullup_n, tri_n, hold_n and cfg_done all 0, with frozen=1 and busy=0.
- R2: A thaw request on an idle frozen bank, sampled at a clock edge, raises hold_n and cfg_done together at that edge. At the same edge busy rises. slew_n, pullup_n and tri_n stay 0.
- R3: GAP cycles after thaw step 1, pullup_n and tri_n rise together. hold_n and cfg_done stay 1.
- R4: GAP cycles after thaw step 2, slew_n rises. In that same cycle busy falls and frozen becomes 0.
- R5: A freeze request on an idle thawed bank drives slew_n, pullup_n and tri_n to 0 together at the sampling edge, and busy rises. hold_n and cfg_done stay 1.
- R6: GAP cycles after freeze step 1, hold_n and cfg_done fall together. In that same cycle busy falls and frozen becomes 1.
- R7: GAP = max(1, ceil(MIN_GAP_PS / CLK_PERIOD_PS)). With the defaults (20000 ps, 8000 ps) GAP is 3. No step's outputs change before GAP cycles have passed.
- R8: Freeze or thaw requests that arrive while a bank is busy are ignored, and the running sequence proceeds unchanged.
- R9: A freeze request on a frozen bank, or a thaw request on a thawed bank, leaves every output unchanged, and busy stays 0.
- R10: If freeze and thaw requests arrive in the same cycle, the freeze request wins and the thaw request is dropped.
- R11: Banks are independent. A request on one bank does not change the outputs of any other bank.
- R12: The frozen flag changes only in the cycle in which busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_req | input | NUM_BANKS | One-cycle freeze request, one bit per bank |
| thaw_req | input | NUM_BANKS | One-cycle thaw request, one bit per bank |
| slew_n | output | NUM_BANKS | Slew enable, active low |
| pullup_n | output | NUM_BANKS | Weak pull-up, active low |
| tri_n | output | NUM_BANKS | Tristate, active low |
| hold_n | output | NUM_BANKS | Bus-hold, active low |
| cfg_done | output | NUM_BANKS | Configuration done, active high |
| frozen | output | NUM_BANKS | 1 = bank frozen, 0 = bank thawed |
| busy | output | NUM_BANKS | Sequence in progress |

## Verification
A request driven in cycle n is sampled at the next edge, so step 1 is visible in cycle n+1. Step 2 appears in cycle n+1+GAP and step 3 in cycle n+1+2·GAP. Busy and the frozen flag settle in the same cycle as the last step. The driver pushes one expected output vector per bank for each of those cycles. It also pushes the cycle just before each step, to catch a step that comes early. The monitor compares only the entries due in the current cycle, sampling on the falling edge. Any entry still left at the end counts as a failure.

// File: rtl/iofrz_pkg.sv
package iofrz_pkg;

    // Per-bank sequencer state.
    typedef enum logic [2:0] {
        ST_FROZEN  = 3'd0,
        ST_FRZ_PAD = 3'd1,
        ST_THAWED  = 3'd2,
        ST_THW_CFG = 3'd3,
        ST_THW_PAD = 3'd4
    } bank_state_e;

    // One bank's pad-control lines.
    typedef struct packed {
        logic slew_n;
        logic pullup_n;
        logic tri_n;
        logic hold_n;
        logic cfg_done;
    } pad_ctl_t;

    // Spacing in cycles, rounded up, floor of one.
    function automatic int unsigned gap_cycles(input int unsigned min_ps,
                                               input int unsigned clk_ps);
        int unsigned raw;
        raw = (min_ps + clk_ps - 1) / clk_ps;
        return (raw < 1) ? 1 : raw;
    endfunction

endpackage

// File: rtl/iofrz_gap_timer.sv
module iofrz_gap_timer #(
    parameter int unsigned GAP_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int unsigned CW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(GAP_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Loaded on entry to a step; expires after GAP_CYCLES edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/iofrz_bank_ctrl.sv
module iofrz_bank_ctrl
    import iofrz_pkg::*;
#(
    parameter int unsigned GAP_CYCLES = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     freeze_req,
    input  logic     thaw_req,
    output pad_ctl_t ctl,
    output logic     frozen,
    output logic     busy
);
    bank_state_e state, state_nx;
    logic        gap_done;
    logic        gap_start;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FROZEN;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions. Requests are only looked at in the idle states,
    // and freeze takes priority over thaw.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FROZEN: begin
                if (thaw_req && !freeze_req) begin
                    state_nx = ST_THW_CFG;
                end
            end
            ST_THAWED: begin
                if (freeze_req) begin
                    state_nx = ST_FRZ_PAD;
                end
            end
            ST_FRZ_PAD: begin
                if (gap_done) begin
                    state_nx = ST_FROZEN;
                end
            end
            ST_THW_CFG: begin
                if (gap_done) begin
                    state_nx = ST_THW_PAD;
                end
            end
            ST_THW_PAD: begin
                if (gap_done) begin
                    state_nx = ST_THAWED;
                end
            end
            default: state_nx = ST_FROZEN;
        endcase
    end

    // Restart the spacing timer whenever a timed step is entered.
    assign gap_start = (state_nx != state) &&
                       ((state_nx == ST_FRZ_PAD) ||
                        (state_nx == ST_THW_CFG) ||
                        (state_nx == ST_THW_PAD));

    iofrz_gap_timer #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (gap_start),
        .expired (gap_done)
    );

    // Output decode.
    always_comb begin
        ctl    = '0;
        frozen = 1'b1;
        busy   = 1'b0;
        unique case (state)
            ST_FROZEN: begin
                ctl    = '{slew_n:1'b0, pullup_n:1'b0, tri_n:1'b0,
                           hold_n:1'b0, cfg_done:1'b0};
                frozen = 1'b1;
                busy   = 1'b0;
            end
            ST_THW_CFG: begin
                ctl    = '{slew_n:1'b0, pullup_n:1'b0, tri_n:1'b0,
                           hold_n:1'b1, cfg_done:1'b1};
                frozen = 1'b1;
                busy   = 1'b1;
            end
            ST_THW_PAD: begin
                ctl    = '{slew_n:1'b0, pullup_n:1'b1, tri_n:1'b1,
                           hold_n:1'b1, cfg_done:1'b1};
                frozen = 1'b1;
                busy   = 1'b1;
            end
            ST_THAWED: begin
                ctl    = '{slew_n:1'b1, pullup_n:1'b1, tri_n:1'b1,
                           hold_n:1'b1, cfg_done:1'b1};
                frozen = 1'b0;
                busy   = 1'b0;
            end
            ST_FRZ_PAD: begin
                ctl    = '{slew_n:1'b0, pullup_n:1'b0, tri_n:1'b0,
                           hold_n:1'b1, cfg_done:1'b1};
                frozen = 1'b0;
                busy   = 1'b1;
            end
            default: begin
                ctl    = '0;
                frozen = 1'b1;
                busy   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/iofrz_seq_top.sv
module iofrz_seq_top
    import iofrz_pkg::*;
#(
    parameter int unsigned NUM_BANKS     = 3,
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned MIN_GAP_PS    = 20000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] freeze_req,
    input  logic [NUM_BANKS-1:0] thaw_req,
    output logic [NUM_BANKS-1:0] slew_n,
    output logic [NUM_BANKS-1:0] pullup_n,
    output logic [NUM_BANKS-1:0] tri_n,
    output logic [NUM_BANKS-1:0] hold_n,
    output logic [NUM_BANKS-1:0] cfg_done,
    output logic [NUM_BANKS-1:0] frozen,
    output logic [NUM_BANKS-1:0] busy
);
    localparam int unsigned GAP_CYCLES = gap_cycles(MIN_GAP_PS, CLK_PERIOD_PS);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pad_ctl_t ctl;

        iofrz_bank_ctrl #(
            .GAP_CYCLES (GAP_CYCLES)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .freeze_req (freeze_req[b]),
            .thaw_req   (thaw_req[b]),
            .ctl        (ctl),
            .frozen     (frozen[b]),
            .busy       (busy[b])
        );

        assign slew_n[b]   = ctl.slew_n;
        assign pullup_n[b] = ctl.pullup_n;
        assign tri_n[b]    = ctl.tri_n;
        assign hold_n[b]   = ctl.hold_n;
        assign cfg_done[b] = ctl.cfg_done;
    end

endmodule

// File: rtl/iofrz_seq_chk.sv
module iofrz_seq_chk #(
    parameter int unsigned NUM_BANKS     = 3,
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned MIN_GAP_PS    = 20000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] freeze_req,
    input logic [NUM_BANKS-1:0] thaw_req,
    input logic [NUM_BANKS-1:0] slew_n,
    input logic [NUM_BANKS-1:0] pullup_n,
    input logic [NUM_BANKS-1:0] tri_n,
    input logic [NUM_BANKS-1:0] hold_n,
    input logic [NUM_BANKS-1:0] cfg_done,
    input logic [NUM_BANKS-1:0] frozen,
    input logic [NUM_BANKS-1:0] busy
);
    localparam int unsigned GAP = iofrz_pkg::gap_cycles(MIN_GAP_PS, CLK_PERIOD_PS);
    localparam int unsigned AW  = $clog2(GAP + 1) + 1;
    localparam logic [AW-1:0] SAT = AW'(GAP);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        logic          slew_q, pull_q, hold_q;
        logic [AW-1:0] age_slew, age_pull, age_hold;

        // Cycles since each line last moved, saturating at GAP.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slew_q   <= 1'b0;
                pull_q   <= 1'b0;
                hold_q   <= 1'b0;
                age_slew <= SAT;
                age_pull <= SAT;
                age_hold <= SAT;
            end else begin
                slew_q   <= slew_n[b];
                pull_q   <= pullup_n[b];
                hold_q   <= hold_n[b];
                age_slew <= (slew_n[b]   != slew_q) ? AW'(1) : ((age_slew < SAT) ? age_slew + 1'b1 : SAT);
                age_pull <= (pullup_n[b] != pull_q) ? AW'(1) : ((age_pull < SAT) ? age_pull + 1'b1 : SAT);
                age_hold <= (hold_n[b]   != hold_q) ? AW'(1) : ((age_hold < SAT) ? age_hold + 1'b1 : SAT);
            end
        end

        AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
            !busy[b] |-> (frozen[b] ? ({slew_n[b], pullup_n[b], tri_n[b], hold_n[b], cfg_done[b]} == 5'b00000)
                                    : ({slew_n[b], pullup_n[b], tri_n[b], hold_n[b], cfg_done[b]} == 5'b11111))); // R1
        AST_HOLD_CFG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
            hold_n[b] == cfg_done[b]); // R2
        AST_THAW_PAD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pullup_n[b]) |-> (hold_n[b] && tri_n[b] && !slew_n[b])); // R3
        AST_THAW_SLEW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(slew_n[b]) |-> (pullup_n[b] && tri_n[b] && !busy[b])); // R4
        AST_FRZ_PAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(slew_n[b]) |-> (!pullup_n[b] && !tri_n[b] && hold_n[b])); // R5
        AST_FRZ_HOLD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(hold_n[b]) |-> (!slew_n[b] && !pullup_n[b] && !tri_n[b] && frozen[b])); // R6
        AST_GAP_PULL: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pullup_n[b]) |-> (age_hold >= SAT)); // R7
        AST_GAP_SLEW: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(slew_n[b]) |-> (age_pull >= SAT)); // R7
        AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(hold_n[b]) |-> (age_slew >= SAT)); // R7
        AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(frozen[b]) |-> $fell(busy[b])); // R12
    end

endmodule

bind iofrz_seq_top iofrz_seq_chk #(
    .NUM_BANKS     (NUM_BANKS),
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .MIN_GAP_PS    (MIN_GAP_PS)
) u_chk (.*);

// File: tb/iofrz_seq_top_test.sv
`timescale 1ns/1ps
module iofrz_seq_top_test;
    localparam int NB = 3;
    localparam int G  = 3; // R7: ceil(20000/8000) = 3

    // Vector order {slew_n, pullup_n, tri_n, hold_n, cfg_done, frozen, busy}
    localparam logic [6:0] V_FROZEN = 7'b0000010;
    localparam logic [6:0] V_THW1   = 7'b0001111;
    localparam logic [6:0] V_THW2   = 7'b0111111;
    localparam logic [6:0] V_THAWED = 7'b1111100;
    localparam logic [6:0] V_FRZ1   = 7'b0001101;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] freeze_req = '0;
    logic [NB-1:0] thaw_req = '0;
    logic [NB-1:0] slew_n, pullup_n, tri_n, hold_n, cfg_done, frozen, busy;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    int         q_cyc[$];
    int         q_bank[$];
    logic [6:0] q_vec[$];
    string      q_tag[$];

    always #4 clk = ~clk;

    iofrz_seq_top #(.NUM_BANKS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
        .slew_n(slew_n), .pullup_n(pullup_n), .tri_n(tri_n), .hold_n(hold_n),
        .cfg_done(cfg_done), .frozen(frozen), .busy(busy)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        for (int i = q_cyc.size() - 1; i >= 0; i--) begin
            if (q_cyc[i] == cyc) begin
                logic [6:0] act;
                int bk;
                bk  = q_bank[i];
                act = {slew_n[bk], pullup_n[bk], tri_n[bk], hold_n[bk],
                       cfg_done[bk], frozen[bk], busy[bk]};
                checks++;
                if (act !== q_vec[i]) begin
                    errors++;
                    $display("FAIL %s bank %0d cycle %0d: actual %b expected %b",
                             q_tag[i], bk, cyc, act, q_vec[i]);
                end
                q_cyc.delete(i); q_bank.delete(i); q_vec.delete(i); q_tag.delete(i);
            end
        end
    end

    task automatic push(input int c, input int b, input logic [6:0] v, input string tag);
        q_cyc.push_back(c); q_bank.push_back(b); q_vec.push_back(v); q_tag.push_back(tag);
    endtask

    task automatic pulse(input int b, input bit f, input bit t);
        freeze_req[b] = f;
        thaw_req[b]   = t;
        @(negedge clk);
        freeze_req[b] = 1'b0;
        thaw_req[b]   = 1'b0;
    endtask

    // Expected thaw timeline for a request driven in the current cycle.
    task automatic exp_thaw(input int b);
        int n;
        n = cyc;
        push(n + 1,         b, V_THW1,   "R2");
        push(n + G,         b, V_THW1,   "R7");
        push(n + G + 1,     b, V_THW2,   "R3");
        push(n + 2 * G,     b, V_THW2,   "R7");
        push(n + 2 * G + 1, b, V_THAWED, "R4");
    endtask

    task automatic exp_freeze(input int b);
        int n;
        n = cyc;
        push(n + 1,     b, V_FRZ1,   "R5");
        push(n + G,     b, V_FRZ1,   "R7");
        push(n + G + 1, b, V_FROZEN, "R6");
    endtask

    task automatic exp_steady(input int b, input logic [6:0] v, input int len, input string tag);
        int n;
        n = cyc;
        for (int k = 1; k <= len; k++) push(n + k, b, v, tag);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on all banks
        for (int b = 0; b < NB; b++) exp_steady(b, V_FROZEN, 2, "R1");
        idle(3);

        // Thaw bank 0; other banks must not move (R11)
        exp_thaw(0);
        exp_steady(1, V_FROZEN, 2 * G + 2, "R11");
        exp_steady(2, V_FROZEN, 2 * G + 2, "R11");
        pulse(0, 1'b0, 1'b1);
        // R8: requests while busy are ignored (timeline above stays)
        pulse(0, 1'b1, 1'b0);
        pulse(0, 1'b0, 1'b1);
        idle(2 * G + 2);

        // R9: redundant thaw on a thawed bank
        exp_steady(0, V_THAWED, 3, "R9");
        pulse(0, 1'b0, 1'b1);
        idle(3);

        // Freeze bank 0, with a thaw request during busy (R8)
        exp_freeze(0);
        pulse(0, 1'b1, 1'b0);
        pulse(0, 1'b0, 1'b1);
        idle(G + 2);

        // R9: redundant freeze on a frozen bank
        exp_steady(0, V_FROZEN, 3, "R9");
        pulse(0, 1'b1, 1'b0);
        idle(3);

        // R10: both requests on frozen bank 2 -> freeze wins, nothing moves
        exp_steady(2, V_FROZEN, 3, "R10");
        pulse(2, 1'b1, 1'b1);
        idle(3);

        // Thaw bank 1 while bank 0 stays frozen (R11)
        exp_thaw(1);
        exp_steady(0, V_FROZEN, 2 * G + 2, "R11");
        pulse(1, 1'b0, 1'b1);
        idle(2 * G + 2);

        // R10: both requests on thawed bank 1 -> freeze sequence
        exp_freeze(1);
        pulse(1, 1'b1, 1'b1);
        idle(G + 3);

        // Overlapping sequences on two banks (R11)
        exp_thaw(0);
        exp_thaw(2);
        freeze_req[2] = 1'b0;
        thaw_req[0] = 1'b1;
        thaw_req[2] = 1'b1;
        @(negedge clk);
        thaw_req = '0;
        idle(2 * G + 3);

        if (q_cyc.size() != 0) begin
            errors += q_cyc.size();
            checks += q_cyc.size();
            $display("FAIL pending: %0d expected items never compared (actual 0, expected 0)", q_cyc.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end (actual timeout, expected finish)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule